// File: doc/BRIEF.md
# Paced Descriptor Accumulator Channel

This block is a single accumulation channel that watches a window of queues held by an external queue manager. The window starts at a programmed base queue number. In wide mode it covers 32 contiguous queues. In narrow mode it covers the base queue only. Whenever a watched queue reports that it holds work, the channel asks the queue manager for one descriptor. It then stores each returned descriptor in the next slot of a host list whose length is programmed.

The channel tells the host through a one-cycle interrupt pulse. The list filling up always raises the pulse. A timer, counted in microseconds from a clock prescaler, can also raise it under one of three pacing policies:
- a delay since the previous interrupt;
- a delay since the first descriptor that entered an empty list;
- a delay since the most recent descriptor.

After any interrupt the channel stops popping and waits for the host to acknowledge. The acknowledge hands the list back with its fill index reset to zero.

Top module: `accum_channel`

## Requirements
- R1: While reset is active and on the first cycle after it, `pop_req`, `list_we` and `irq` are all low.
- R2: In wide mode (`cfg_wide`=1) every pop request names a queue in the range `cfg_base_q` to `cfg_base_q`+31, and every watched non-empty queue is eventually popped.
- R3: In narrow mode (`cfg_wide`=0) only `cfg_base_q` is popped, even when other flags in `q_nonempty` are set.
- R4: Watched queues are served round-robin, starting the search at the offset after the one last served. `pop_req` is a one-cycle pulse, and no new request is issued before `pop_ack` has returned the outstanding one.
- R5: One cycle after `pop_ack`, `list_we` pulses with `list_data` equal to the popped descriptor. `list_idx` counts 0, 1, 2 … in the order the descriptors arrive.
- R6: The write that fills the list (index `cfg_entries`-1) carries `irq` in the same cycle, whatever the pacing mode.
- R7: After `irq`, no pop is issued until `irq_ack` is seen. The next descriptor after the acknowledge is written at index 0.
- R8: Pacing code 0 raises `irq` only on a full list.
- R9: Pacing code 1 also raises `irq` once `cfg_delay_us` microseconds have passed since the previous interrupt (or since reset).
- R10: Pacing code 2 also raises `irq` once `cfg_delay_us` microseconds have passed since the first descriptor written into an empty list.
- R11: Pacing code 3 also raises `irq` once `cfg_delay_us` microseconds have passed since the latest descriptor write. Each write restarts that delay.
- R12: A timer expiry while the list holds no entries raises no interrupt, in any pacing mode.
- R13: One microsecond equals `CLK_PER_US` clock cycles, counted by a free-running prescaler that starts at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_q | input | QNUM_W | First queue number of the watched window |
| cfg_wide | input | 1 | 1: watch 32 queues, 0: watch the base queue only |
| cfg_entries | input | CNT_W | List length in descriptors (1 to MAX_ENTRIES) |
| cfg_mode | input | 2 | Pacing code 0..3 |
| cfg_delay_us | input | LAT_W | Pacing delay in microseconds |
| q_nonempty | input | NQ | Per-offset non-empty flags of the watched queues |
| pop_req | output | 1 | One-cycle pop request to the queue manager |
| pop_qnum | output | QNUM_W | Queue number of the pop request |
| pop_ack | input | 1 | Pop response valid |
| pop_data | input | DW | Popped descriptor |
| list_we | output | 1 | Host list write strobe |
| list_idx | output | IDX_W | Host list slot being written |
| list_data | output | DW | Descriptor being written |
| irq | output | 1 | One-cycle host interrupt pulse |
| irq_ack | input | 1 | Host acknowledge that frees the list |

## Verification
- A pop request appears one cycle after the edge at which a watched non-empty flag is seen while the channel is idle.
- The list write, and any list-full interrupt, appear one cycle after the edge that samples `pop_ack`.
- A timer interrupt appears one cycle after the edge at which the elapsed microsecond count first reaches the delay while the channel is idle and the list is non-empty.
- The bench runs a behavioural model that updates at each rising edge from the same inputs. Every output is compared with the model at the following falling edge, so each result is checked in exactly the cycle it is due. Queue contents and interrupt counts are also checked at the end of each scenario.

// File: rtl/accum_pkg.sv
package accum_pkg;

  typedef enum logic [1:0] {
    ST_POLL = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } acc_state_e;

  typedef enum logic [1:0] {
    PACE_FULL_ONLY   = 2'd0,
    PACE_SINCE_IRQ   = 2'd1,
    PACE_SINCE_FIRST = 2'd2,
    PACE_SINCE_LAST  = 2'd3
  } pace_mode_e;

  // Restart of the pacing timer for the selected policy.
  function automatic logic pace_restart(input pace_mode_e mode, input logic wr,
                                        input logic was_empty, input logic irq_ev);
    case (mode)
      PACE_SINCE_IRQ:   return irq_ev;
      PACE_SINCE_FIRST: return wr && was_empty;
      PACE_SINCE_LAST:  return wr;
      default:          return 1'b0;
    endcase
  endfunction

  // Event-started policies stop timing once an interrupt has been raised.
  function automatic logic pace_disarm(input pace_mode_e mode, input logic irq_ev);
    return irq_ev && (mode == PACE_SINCE_FIRST || mode == PACE_SINCE_LAST);
  endfunction

endpackage

// File: rtl/acc_us_tick.sv
module acc_us_tick #(
  parameter int CLK_PER_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic us_tick
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  generate
    if (CLK_PER_US <= 1) begin : g_direct
      assign us_tick = 1'b1;
    end else begin : g_count
      logic [PRE_W-1:0] pre_q;
      assign us_tick = (pre_q == PRE_W'(CLK_PER_US - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_q <= '0;
        else if (us_tick) pre_q <= '0;
        else              pre_q <= pre_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/acc_pace_timer.sv
module acc_pace_timer #(
  parameter int LAT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             restart,
  input  logic             disarm,
  input  logic [LAT_W-1:0] delay_us,
  output logic             due
);
  logic [LAT_W-1:0] elapsed_q;
  logic             armed_q;

  assign due = armed_q && (elapsed_q >= delay_us);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      armed_q   <= 1'b1;
    end else if (disarm) begin
      armed_q   <= 1'b0;
    end else if (restart) begin
      elapsed_q <= '0;
      armed_q   <= 1'b1;
    end else if (us_tick && armed_q && (elapsed_q != '1)) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end
endmodule

// File: rtl/acc_queue_poller.sv
module acc_queue_poller #(
  parameter int NQ     = 32,
  parameter int QNUM_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NQ-1:0]     q_nonempty,
  input  logic              wide,
  input  logic [QNUM_W-1:0] base_q,
  input  logic              launch,
  output logic              pick_valid,
  output logic [QNUM_W-1:0] pick_qnum
);
  localparam int PTR_W = (NQ > 1) ? $clog2(NQ) : 1;

  logic [PTR_W-1:0] ptr_q;
  logic [NQ-1:0]    watch;
  logic [PTR_W:0]   pick;

  // First set bit at or after start, wrapping; result {found, offset}.
  function automatic logic [PTR_W:0] rr_pick(input logic [NQ-1:0] req,
                                             input logic [PTR_W-1:0] start);
    logic [PTR_W:0] res;
    res = '0;
    for (int k = NQ - 1; k >= 0; k--) begin
      int off;
      off = (int'(start) + k) % NQ;
      if (req[off]) res = {1'b1, PTR_W'(off)};
    end
    return res;
  endfunction

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] cur);
    return (int'(cur) == NQ - 1) ? '0 : cur + 1'b1;
  endfunction

  assign watch      = wide ? q_nonempty : {{(NQ-1){1'b0}}, q_nonempty[0]};
  assign pick       = rr_pick(watch, ptr_q);
  assign pick_valid = pick[PTR_W];
  assign pick_qnum  = base_q + QNUM_W'(pick[PTR_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (launch) ptr_q <= next_ptr(pick[PTR_W-1:0]);
  end
endmodule

// File: rtl/accum_channel.sv
module accum_channel
  import accum_pkg::*;
#(
  parameter int NQ          = 32,
  parameter int QNUM_W      = 14,
  parameter int DW          = 32,
  parameter int MAX_ENTRIES = 16,
  parameter int LAT_W       = 10,
  parameter int CLK_PER_US  = 200,
  localparam int CNT_W      = $clog2(MAX_ENTRIES + 1),
  localparam int IDX_W      = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QNUM_W-1:0] cfg_base_q,
  input  logic              cfg_wide,
  input  logic [CNT_W-1:0]  cfg_entries,
  input  logic [1:0]        cfg_mode,
  input  logic [LAT_W-1:0]  cfg_delay_us,
  input  logic [NQ-1:0]     q_nonempty,
  output logic              pop_req,
  output logic [QNUM_W-1:0] pop_qnum,
  input  logic              pop_ack,
  input  logic [DW-1:0]     pop_data,
  output logic              list_we,
  output logic [IDX_W-1:0]  list_idx,
  output logic [DW-1:0]     list_data,
  output logic              irq,
  input  logic              irq_ack
);
  acc_state_e        st_q;
  logic [CNT_W-1:0]  fill_q;
  pace_mode_e        mode;

  // Named internal events
  logic              us_tick;
  logic              timer_due;
  logic              pick_valid;
  logic [QNUM_W-1:0] pick_qnum;
  logic              evt_write;
  logic              evt_full;
  logic              evt_timer_fire;
  logic              evt_irq;
  logic              evt_launch;
  logic              evt_release;
  logic              tmr_restart;
  logic              tmr_disarm;

  assign mode           = pace_mode_e'(cfg_mode);
  assign evt_write      = (st_q == ST_WAIT) && pop_ack;
  assign evt_full       = evt_write && ((fill_q + CNT_W'(1)) == cfg_entries);
  assign evt_timer_fire = (st_q == ST_POLL) && (mode != PACE_FULL_ONLY) &&
                          timer_due && (fill_q != '0);
  assign evt_irq        = evt_full || evt_timer_fire;
  assign evt_launch     = (st_q == ST_POLL) && !evt_timer_fire && pick_valid;
  assign evt_release    = (st_q == ST_HOLD) && irq_ack;
  assign tmr_restart    = pace_restart(mode, evt_write, fill_q == '0, evt_irq);
  assign tmr_disarm     = pace_disarm(mode, evt_irq);

  acc_us_tick #(.CLK_PER_US(CLK_PER_US)) tick_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .us_tick (us_tick)
  );

  acc_pace_timer #(.LAT_W(LAT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .us_tick  (us_tick),
    .restart  (tmr_restart),
    .disarm   (tmr_disarm),
    .delay_us (cfg_delay_us),
    .due      (timer_due)
  );

  acc_queue_poller #(.NQ(NQ), .QNUM_W(QNUM_W)) poller_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_nonempty (q_nonempty),
    .wide       (cfg_wide),
    .base_q     (cfg_base_q),
    .launch     (evt_launch),
    .pick_valid (pick_valid),
    .pick_qnum  (pick_qnum)
  );

  // Channel sequencing: poll -> wait for pop -> (hold for host)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_POLL;
      fill_q <= '0;
    end else begin
      case (st_q)
        ST_POLL: begin
          if (evt_timer_fire)  st_q <= ST_HOLD;
          else if (evt_launch) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (evt_write) begin
            fill_q <= fill_q + 1'b1;
            st_q   <= evt_full ? ST_HOLD : ST_POLL;
          end
        end
        ST_HOLD: begin
          if (evt_release) begin
            fill_q <= '0;
            st_q   <= ST_POLL;
          end
        end
        default: st_q <= ST_POLL;
      endcase
    end
  end

  // Registered outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_req   <= 1'b0;
      pop_qnum  <= '0;
      list_we   <= 1'b0;
      list_idx  <= '0;
      list_data <= '0;
      irq       <= 1'b0;
    end else begin
      pop_req <= evt_launch;
      list_we <= evt_write;
      irq     <= evt_irq;
      if (evt_launch) pop_qnum <= pick_qnum;
      if (evt_write) begin
        list_idx  <= fill_q[IDX_W-1:0];
        list_data <= pop_data;
      end
    end
  end
endmodule

// File: rtl/accum_channel_chk.sv
module accum_channel_chk #(
  parameter int NQ          = 32,
  parameter int QNUM_W      = 14,
  parameter int CNT_W       = 5,
  parameter int IDX_W       = 4,
  parameter int CLK_PER_US  = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic [QNUM_W-1:0] cfg_base_q,
  input logic              cfg_wide,
  input logic [CNT_W-1:0]  cfg_entries,
  input logic [1:0]        cfg_mode,
  input logic              pop_req,
  input logic [QNUM_W-1:0] pop_qnum,
  input logic              pop_ack,
  input logic              list_we,
  input logic [IDX_W-1:0]  list_idx,
  input logic              irq,
  input logic [CNT_W-1:0]  fill_q,
  input logic              us_tick
);
  logic [QNUM_W-1:0] q_off;
  assign q_off = pop_qnum - cfg_base_q;

  // R2
  wide_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |-> (int'(q_off) < NQ));

  // R3
  narrow_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !cfg_wide) |-> (pop_qnum == cfg_base_q));

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |=> !pop_req);

  // R5
  write_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    list_we |-> $past(pop_ack));

  // R6
  full_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (list_we && ((CNT_W'(list_idx) + CNT_W'(1)) == cfg_entries)) |-> irq);

  // R7
  hold_after_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !pop_req);

  // R8
  mode0_full_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && cfg_mode == 2'd0) |-> list_we);

  // R12
  irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (fill_q != '0));

  // R13
  generate
    if (CLK_PER_US > 1) begin : g_tick_chk
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        us_tick |=> !us_tick);
    end
  endgenerate
endmodule

bind accum_channel accum_channel_chk #(
  .NQ(NQ), .QNUM_W(QNUM_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .CLK_PER_US(CLK_PER_US)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_base_q  (cfg_base_q),
  .cfg_wide    (cfg_wide),
  .cfg_entries (cfg_entries),
  .cfg_mode    (cfg_mode),
  .pop_req     (pop_req),
  .pop_qnum    (pop_qnum),
  .pop_ack     (pop_ack),
  .list_we     (list_we),
  .list_idx    (list_idx),
  .irq         (irq),
  .fill_q      (fill_q),
  .us_tick     (us_tick)
);

// File: tb/accum_channel_tb_top.sv
module accum_channel_tb_top;
  localparam int NQ = 32, QNUM_W = 14, DW = 32, MAXE = 16, LAT_W = 10, CPU = 200;
  localparam int CNT_W = 5, IDX_W = 4;
  localparam int LMAX = (1 << LAT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [QNUM_W-1:0] cfg_base_q = '0;
  logic cfg_wide = 1'b1;
  logic [CNT_W-1:0] cfg_entries = 5'd4;
  logic [1:0] cfg_mode = 2'd0;
  logic [LAT_W-1:0] cfg_delay_us = '0;
  logic [NQ-1:0] q_nonempty;
  logic pop_req, pop_ack = 1'b0, list_we, irq, irq_ack = 1'b0;
  logic [QNUM_W-1:0] pop_qnum;
  logic [DW-1:0] pop_data = '0, list_data;
  logic [IDX_W-1:0] list_idx;

  int qcnt [NQ];
  int checks = 0, errors = 0, irq_seen = 0, seq = 0;
  string ph_tag = "R1";

  always #2.5 clk = ~clk;

  accum_channel dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_base_q(cfg_base_q), .cfg_wide(cfg_wide),
    .cfg_entries(cfg_entries), .cfg_mode(cfg_mode), .cfg_delay_us(cfg_delay_us),
    .q_nonempty(q_nonempty), .pop_req(pop_req), .pop_qnum(pop_qnum),
    .pop_ack(pop_ack), .pop_data(pop_data), .list_we(list_we), .list_idx(list_idx),
    .list_data(list_data), .irq(irq), .irq_ack(irq_ack)
  );

  always_comb
    for (int i = 0; i < NQ; i++) q_nonempty[i] = (qcnt[i] != 0);

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_st, m_ptr, m_fill, m_pre, m_elapsed;
  bit m_armed, e_popreq, e_we, e_irq;
  int e_qnum, e_idx;
  logic [DW-1:0] e_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ptr = 0; m_fill = 0; m_pre = 0; m_elapsed = 0; m_armed = 1;
      e_popreq = 0; e_we = 0; e_irq = 0; e_qnum = 0; e_idx = 0; e_data = '0;
    end else begin
      bit tick, wr, full, tfire, ev, rs;
      tick  = (m_pre == CPU - 1);
      m_pre = tick ? 0 : m_pre + 1;
      wr    = (m_st == 1) && pop_ack;
      full  = wr && (m_fill + 1 == int'(cfg_entries));
      tfire = (m_st == 0) && (cfg_mode != 0) && m_armed &&
              (m_elapsed >= int'(cfg_delay_us)) && (m_fill > 0);
      ev    = full || tfire;
      e_we = wr; e_irq = ev; e_popreq = 0;
      if (wr) begin e_idx = m_fill; e_data = pop_data; end
      if (cfg_mode == 1)      rs = ev;
      else if (cfg_mode == 2) rs = wr && (m_fill == 0);
      else if (cfg_mode == 3) rs = wr;
      else                    rs = 0;
      if (ev && cfg_mode >= 2)   m_armed = 0;
      else if (rs)               begin m_elapsed = 0; m_armed = 1; end
      else if (tick && m_armed && m_elapsed < LMAX) m_elapsed++;
      if (m_st == 0) begin
        if (tfire) m_st = 2;
        else begin
          for (int k = 0; k < NQ; k++) begin
            int o;
            o = (m_ptr + k) % NQ;
            if ((cfg_wide || o == 0) && q_nonempty[o] && !e_popreq) begin
              e_popreq = 1; e_qnum = int'(cfg_base_q) + o;
              m_ptr = (o + 1) % NQ; m_st = 1;
            end
          end
        end
      end else if (m_st == 1) begin
        if (wr) begin m_fill++; m_st = full ? 2 : 0; end
      end else if (irq_ack) begin
        m_fill = 0; m_st = 0;
      end
    end
  end

  // compare every cycle at the falling edge
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      chk(pop_req == e_popreq, ph_tag, "pop_req", pop_req, e_popreq);
      if (e_popreq) chk(int'(pop_qnum) == e_qnum, ph_tag, "pop_qnum", pop_qnum, e_qnum);
      chk(list_we == e_we, ph_tag, "list_we", list_we, e_we);
      if (e_we) begin
        chk(int'(list_idx) == e_idx, ph_tag, "list_idx", list_idx, e_idx);
        chk(list_data == e_data, ph_tag, "list_data", list_data, e_data);
      end
      chk(irq == e_irq, ph_tag, "irq", irq, e_irq);
    end
  end

  // queue manager and host responder
  initial begin
    int wait_pop, wait_ack, off;
    wait_pop = 0; wait_ack = 0; off = 0;
    forever begin
      @(negedge clk);
      pop_ack = 0; irq_ack = 0;
      if (!rst_n) begin wait_pop = 0; wait_ack = 0; end
      else begin
        if (wait_pop > 0) begin
          wait_pop--;
          if (wait_pop == 0) begin
            seq++;
            pop_ack = 1; pop_data = (off << 16) | seq;
            if (qcnt[off] > 0) qcnt[off]--;
          end
        end
        if (pop_req) begin wait_pop = 2; off = int'(pop_qnum - cfg_base_q) % NQ; end
        if (wait_ack > 0) begin
          wait_ack--;
          if (wait_ack == 0) irq_ack = 1;
        end
        if (irq) begin irq_seen++; wait_ack = 3; end
      end
    end
  end

  task automatic start_phase(input string tag, input int base, input bit wide,
                             input int entries, input int mode, input int dly);
    @(posedge clk); #1 rst_n = 0;
    ph_tag = tag;
    for (int i = 0; i < NQ; i++) qcnt[i] = 0;
    cfg_base_q = QNUM_W'(base); cfg_wide = wide; cfg_entries = CNT_W'(entries);
    cfg_mode = 2'(mode); cfg_delay_us = LAT_W'(dly); irq_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic add_desc(input int q, input int n);
    @(negedge clk);
    qcnt[q] += n;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int sum;
    // R1 reset state
    start_phase("R1", 0, 1, 4, 0, 0);
    @(negedge clk);
    chk(!pop_req && !list_we && !irq, "R1", "outputs after reset",
        {pop_req, list_we, irq}, 0);

    // R2/R4/R5/R6/R7/R8: wide round-robin, list full, then a stuck partial list
    start_phase("R4", 100, 1, 4, 0, 1);
    qcnt[3] = 2; qcnt[7] = 2; qcnt[31] = 2;
    idle(3000);
    sum = qcnt[3] + qcnt[7] + qcnt[31];
    chk(sum == 0, "R2", "descriptors left in window", sum, 0);
    chk(irq_seen == 1, "R8", "interrupts in full-only mode", irq_seen, 1);

    // R3 narrow mode
    start_phase("R3", 40, 0, 8, 0, 1);
    qcnt[0] = 2; qcnt[5] = 3;
    idle(500);
    chk(qcnt[5] == 3, "R3", "unwatched queue untouched", qcnt[5], 3);
    chk(qcnt[0] == 0, "R3", "base queue drained", qcnt[0], 0);

    // R9/R13 delay since last interrupt, R12 empty list stays quiet
    start_phase("R9", 200, 1, 8, 1, 3);
    qcnt[10] = 2;
    idle(3000);
    chk(irq_seen == 1, "R9", "timer interrupts since last irq", irq_seen, 1);
    chk(qcnt[10] == 0, "R12", "queue drained", qcnt[10], 0);

    // R10 delay since first descriptor
    start_phase("R10", 300, 1, 8, 2, 4);
    add_desc(2, 1);
    idle(300);
    add_desc(6, 1);
    idle(4000);
    chk(irq_seen == 1, "R10", "interrupts since first", irq_seen, 1);

    // R11 delay since latest descriptor
    start_phase("R11", 500, 1, 8, 3, 4);
    add_desc(1, 1); idle(600);
    add_desc(1, 1); idle(600);
    chk(irq_seen == 0, "R11", "no irq while descriptors keep arriving", irq_seen, 0);
    add_desc(1, 1);
    idle(3000);
    chk(irq_seen == 1, "R11", "interrupts since latest", irq_seen, 1);

    // R6 full in a timed mode, then timer empties the remainder
    start_phase("R6", 700, 1, 2, 3, 20);
    qcnt[9] = 3;
    idle(5000);
    chk(irq_seen == 2, "R6", "full then timer interrupt", irq_seen, 2);

    finish_run();
  end
endmodule